// File: doc/BRIEF.md
# Data-Side Address Translation and Fault Checker

This block turns a data-access virtual address into a physical address and decides whether the access may proceed. On each request it evaluates a fixed chain of checks:

- the access is aligned to its size;
- the virtual address is properly sign-extended;
- a kernel-only direct-mapped window is decoded;
- the attached TLB's hit/miss result is consumed;
- read and write permissions are applied for the effective processor mode;
- fault-on-read and fault-on-write traps are applied;
- the resulting physical address is rejected if it lies beyond the implemented range.

The first check that fails determines the fault. A successful access yields a 44-bit physical address and an uncacheable flag. The flag is decoded from physical bit 39; when it is set, the address field bits 42:35 are cleared.

The TLB itself is outside the block. The TLB sees the same virtual address and returns a hit flag, a physical page number, per-mode read and write enable masks, and the two fault-on-access bits, all in the request cycle. The result is captured in one register stage.

A two-state controller sequences the response. `ST_IDLE` moves to `ST_RESP` when `req_valid` is high. `ST_RESP` stays in `ST_RESP` while `req_valid` stays high, and returns to `ST_IDLE` when it drops. `rsp_valid` is high exactly in `ST_RESP`.

Top module: `dxl_translate`

## Requirements
- R1: After reset `rsp_valid` is 0 and `fault` is 0. A request sampled at a rising edge with `req_valid` high produces `rsp_valid`=1 with its results after that edge; with `req_valid` low, `rsp_valid` is 0 after the next edge.
- R2: If `va[2:0] & ((1<<size_log2)-1)` is nonzero, the fault is ALIGN (code 1) and the status is only the WR bit (bit 0), which equals `is_write`. This check wins over every other check.
- R3: Modes are encoded kernel=0, executive=1, supervisor=2, user=3. The effective mode is `cur_mode` when `pal_mode`=0. When `pal_mode`=1 it is `alt_mode` if `alt_req`=1, and kernel otherwise. Permission checks index the enable masks with the effective mode.
- R4: With `phys_req`=1, the raw physical address is `va`. The sign-extension check, the direct-mapped window decode and all TLB inputs are ignored.
- R5: With `phys_req`=0, if `va[63:42]` is neither all zeros nor all ones, the fault is PAGE (code 5) with status BADVA (bit 5) | ACV (bit 1) | WR.
- R6: With `phys_req`=0 and `sp_enable`=1, `va[47:41]`=7'h7E selects the direct-mapped window. If `cur_mode` (not the effective mode) is not kernel, the fault is ACV (code 2) with status ACV|WR. Otherwise the address is `va[43:0]`, with bits 43:40 set to ones if bit 40 is 1 and to zeros otherwise. The TLB inputs are ignored.
- R7: On the TLB path, `tlb_hit`=0 gives a miss fault with status MISS (bit 4) | WR. The fault is PTE_MISS (code 4) if `pte_fetch`=1 and MISS (code 3) otherwise.
- R8: On a TLB hit, the raw physical address is `(tlb_ppn << 13) | va[12:0]`.
- R9: On a TLB-hit write, a clear `tlb_wr_en[mode]` gives PAGE with status WR|ACV|FONW, where FONW (bit 3) is present only if `tlb_fonw`=1. If the write is permitted and `tlb_fonw`=1, the result is PAGE with WR|FONW.
- R10: On a TLB-hit read, a clear `tlb_rd_en[mode]` gives ACV with status ACV|FONR, where FONR (bit 2) is present only if `tlb_fonr`=1. If the read is permitted and `tlb_fonr`=1, the result is PAGE with FONR only.
- R11: If no earlier fault applies and any raw physical address bit above 43 is set, the fault is MCHK (code 6) with status 0.
- R12: On success (code 0, status 0), `pa` is the raw address bits 43:0. If bit 39 is set, `uncacheable`=1 and `pa[42:35]` are cleared.
- R13: Whenever the fault is nonzero, `pa`=0 and `uncacheable`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| va | input | 64 | Virtual address |
| size_log2 | input | 2 | Access size as log2 of bytes |
| is_write | input | 1 | 1 for store, 0 for load |
| phys_req | input | 1 | Address is already physical |
| alt_req | input | 1 | Use alternate mode while in PAL mode |
| pal_mode | input | 1 | Privileged-code mode active |
| cur_mode | input | 2 | Current processor mode |
| alt_mode | input | 2 | Alternate processor mode |
| sp_enable | input | 1 | Direct-mapped window enable |
| pte_fetch | input | 1 | Request is a page-table-entry fetch |
| tlb_hit | input | 1 | TLB lookup hit |
| tlb_ppn | input | PPN_W | Physical page number from TLB |
| tlb_rd_en | input | 4 | Per-mode read enables |
| tlb_wr_en | input | 4 | Per-mode write enables |
| tlb_fonr | input | 1 | Fault-on-read bit |
| tlb_fonw | input | 1 | Fault-on-write bit |
| rsp_valid | output | 1 | Result valid |
| pa | output | 44 | Physical address |
| uncacheable | output | 1 | Access is uncached |
| fault | output | 3 | Fault code |
| status | output | 6 | Fault status bits |

## Verification
The assertions assume that all request inputs, including the TLB's result, are stable and meaningful whenever `req_valid` is high. They also assume that `req_valid` is low throughout reset. The bench drives every input half a clock away from the capturing edge. It keeps `req_valid` low until reset is released, and it supplies TLB fields as fixed values rather than modelling a lookup. The sweeps run over all mode, enable-mask and trap-bit combinations, plus chosen address patterns for each boundary.

// File: rtl/dxl_pkg.sv
package dxl_pkg;
    localparam int VA_W      = 64;
    localparam int PA_W      = 44;
    localparam int VA_SIGN   = 42;
    localparam int SP_HI     = 47;
    localparam int SP_LO     = 41;
    localparam logic [SP_HI-SP_LO:0] SP_TAG = 7'h7E;
    localparam int SEXT_BIT  = 40;
    localparam int UC_BIT    = 39;
    localparam int UC_CLR_HI = 42;
    localparam int UC_CLR_LO = 35;
    localparam int NUM_MODES = 4;
    localparam int ST_W      = 6;

    localparam int ST_WR    = 0;
    localparam int ST_ACV   = 1;
    localparam int ST_FONR  = 2;
    localparam int ST_FONW  = 3;
    localparam int ST_MISS  = 4;
    localparam int ST_BADVA = 5;

    localparam logic [1:0] MODE_KERNEL = 2'd0;

    typedef enum logic [2:0] {
        FLT_NONE     = 3'd0,
        FLT_ALIGN    = 3'd1,
        FLT_ACV      = 3'd2,
        FLT_MISS     = 3'd3,
        FLT_PTE_MISS = 3'd4,
        FLT_PAGE     = 3'd5,
        FLT_MCHK     = 3'd6
    } fault_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } ctl_state_e;
endpackage

// File: rtl/dxl_align_chk.sv
module dxl_align_chk (
    input  logic [2:0] va_low,
    input  logic [1:0] size_log2,
    output logic       misaligned
);
    logic [3:0] span_mask;

    always_comb begin
        span_mask  = (4'd1 << size_log2) - 4'd1;
        misaligned = |(va_low & span_mask[2:0]);
    end
endmodule

// File: rtl/dxl_addr_map.sv
module dxl_addr_map
    import dxl_pkg::*;
#(
    parameter int PPN_W      = 32,
    parameter int PAGE_SHIFT = 13
) (
    input  logic [VA_W-1:0]  va,
    input  logic             phys_req,
    input  logic             sp_enable,
    input  logic [1:0]       cur_mode,
    input  logic [PPN_W-1:0] tlb_ppn,
    output logic             bad_va,
    output logic             sp_hit,
    output logic             sp_deny,
    output logic [VA_W-1:0]  raw_pa
);
    localparam int UPPER_W = VA_W - VA_SIGN;

    logic [UPPER_W-1:0] upper;
    logic [VA_W-1:0]    sp_pa;
    logic [VA_W-1:0]    tlb_pa;

    always_comb begin
        upper   = va[VA_W-1:VA_SIGN];
        bad_va  = !phys_req && !((&upper) || !(|upper));
        sp_hit  = !phys_req && !bad_va && sp_enable && (va[SP_HI:SP_LO] == SP_TAG);
        sp_deny = sp_hit && (cur_mode != MODE_KERNEL);

        sp_pa = '0;
        sp_pa[PA_W-1:0] = va[PA_W-1:0];
        if (sp_pa[SEXT_BIT]) begin
            sp_pa[PA_W-1:SEXT_BIT] = '1;
        end else begin
            sp_pa[PA_W-1:SEXT_BIT] = '0;
        end

        tlb_pa = (VA_W'(tlb_ppn) << PAGE_SHIFT) | VA_W'(va[PAGE_SHIFT-1:0]);

        if (phys_req) begin
            raw_pa = va;
        end else if (sp_hit) begin
            raw_pa = sp_pa;
        end else begin
            raw_pa = tlb_pa;
        end
    end
endmodule

// File: rtl/dxl_perm_chk.sv
module dxl_perm_chk
    import dxl_pkg::*;
(
    input  logic                 is_write,
    input  logic [1:0]           eff_mode,
    input  logic [NUM_MODES-1:0] rd_en,
    input  logic [NUM_MODES-1:0] wr_en,
    input  logic                 fonr,
    input  logic                 fonw,
    output logic                 perm_fault,
    output fault_e               perm_code,
    output logic [ST_W-1:0]      perm_status
);
    always_comb begin
        perm_fault  = 1'b0;
        perm_code   = FLT_NONE;
        perm_status = '0;
        if (is_write) begin
            if (!wr_en[eff_mode]) begin
                perm_fault            = 1'b1;
                perm_code             = FLT_PAGE;
                perm_status[ST_WR]    = 1'b1;
                perm_status[ST_ACV]   = 1'b1;
                perm_status[ST_FONW]  = fonw;
            end else if (fonw) begin
                perm_fault            = 1'b1;
                perm_code             = FLT_PAGE;
                perm_status[ST_WR]    = 1'b1;
                perm_status[ST_FONW]  = 1'b1;
            end
        end else begin
            if (!rd_en[eff_mode]) begin
                perm_fault            = 1'b1;
                perm_code             = FLT_ACV;
                perm_status[ST_ACV]   = 1'b1;
                perm_status[ST_FONR]  = fonr;
            end else if (fonr) begin
                perm_fault            = 1'b1;
                perm_code             = FLT_PAGE;
                perm_status[ST_FONR]  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/dxl_phys_post.sv
module dxl_phys_post
    import dxl_pkg::*;
(
    input  logic [VA_W-1:0] raw_pa,
    output logic            mchk,
    output logic [PA_W-1:0] pa_out,
    output logic            uc
);
    always_comb begin
        mchk   = |raw_pa[VA_W-1:PA_W];
        pa_out = raw_pa[PA_W-1:0];
        uc     = pa_out[UC_BIT];
        if (uc) begin
            pa_out[UC_CLR_HI:UC_CLR_LO] = '0;
        end
    end
endmodule

// File: rtl/dxl_translate.sv
module dxl_translate
    import dxl_pkg::*;
#(
    parameter int PPN_W      = 32,
    parameter int PAGE_SHIFT = 13
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [VA_W-1:0]      va,
    input  logic [1:0]           size_log2,
    input  logic                 is_write,
    input  logic                 phys_req,
    input  logic                 alt_req,
    input  logic                 pal_mode,
    input  logic [1:0]           cur_mode,
    input  logic [1:0]           alt_mode,
    input  logic                 sp_enable,
    input  logic                 pte_fetch,
    input  logic                 tlb_hit,
    input  logic [PPN_W-1:0]     tlb_ppn,
    input  logic [NUM_MODES-1:0] tlb_rd_en,
    input  logic [NUM_MODES-1:0] tlb_wr_en,
    input  logic                 tlb_fonr,
    input  logic                 tlb_fonw,
    output logic                 rsp_valid,
    output logic [PA_W-1:0]      pa,
    output logic                 uncacheable,
    output logic [2:0]           fault,
    output logic [ST_W-1:0]      status
);
    ctl_state_e state, state_nx;

    logic            misaligned;
    logic            bad_va, sp_hit, sp_deny;
    logic [VA_W-1:0] raw_pa;
    logic [1:0]      eff_mode;
    logic            perm_fault;
    fault_e          perm_code;
    logic [ST_W-1:0] perm_status;
    logic            mchk;
    logic [PA_W-1:0] post_pa;
    logic            post_uc;
    logic            tlb_path;

    fault_e          nx_fault;
    logic [ST_W-1:0] nx_status;
    logic [PA_W-1:0] nx_pa;
    logic            nx_unc;

    dxl_align_chk u_align (
        .va_low     (va[2:0]),
        .size_log2  (size_log2),
        .misaligned (misaligned)
    );

    dxl_addr_map #(.PPN_W(PPN_W), .PAGE_SHIFT(PAGE_SHIFT)) u_map (
        .va        (va),
        .phys_req  (phys_req),
        .sp_enable (sp_enable),
        .cur_mode  (cur_mode),
        .tlb_ppn   (tlb_ppn),
        .bad_va    (bad_va),
        .sp_hit    (sp_hit),
        .sp_deny   (sp_deny),
        .raw_pa    (raw_pa)
    );

    always_comb begin
        if (pal_mode) begin
            eff_mode = alt_req ? alt_mode : MODE_KERNEL;
        end else begin
            eff_mode = cur_mode;
        end
    end

    dxl_perm_chk u_perm (
        .is_write    (is_write),
        .eff_mode    (eff_mode),
        .rd_en       (tlb_rd_en),
        .wr_en       (tlb_wr_en),
        .fonr        (tlb_fonr),
        .fonw        (tlb_fonw),
        .perm_fault  (perm_fault),
        .perm_code   (perm_code),
        .perm_status (perm_status)
    );

    dxl_phys_post u_post (
        .raw_pa (raw_pa),
        .mchk   (mchk),
        .pa_out (post_pa),
        .uc     (post_uc)
    );

    // Fault priority chain
    always_comb begin
        tlb_path  = !phys_req && !sp_hit;
        nx_fault  = FLT_NONE;
        nx_status = '0;
        nx_pa     = '0;
        nx_unc    = 1'b0;
        if (misaligned) begin
            nx_fault           = FLT_ALIGN;
            nx_status[ST_WR]   = is_write;
        end else if (bad_va) begin
            nx_fault            = FLT_PAGE;
            nx_status[ST_WR]    = is_write;
            nx_status[ST_ACV]   = 1'b1;
            nx_status[ST_BADVA] = 1'b1;
        end else if (sp_deny) begin
            nx_fault          = FLT_ACV;
            nx_status[ST_WR]  = is_write;
            nx_status[ST_ACV] = 1'b1;
        end else if (tlb_path && !tlb_hit) begin
            nx_fault           = pte_fetch ? FLT_PTE_MISS : FLT_MISS;
            nx_status[ST_WR]   = is_write;
            nx_status[ST_MISS] = 1'b1;
        end else if (tlb_path && perm_fault) begin
            nx_fault  = perm_code;
            nx_status = perm_status;
        end else if (mchk) begin
            nx_fault = FLT_MCHK;
        end else begin
            nx_pa  = post_pa;
            nx_unc = post_uc;
        end
    end

    // Next-state logic
    always_comb begin
        unique case (state)
            ST_IDLE: state_nx = req_valid ? ST_RESP : ST_IDLE;
            ST_RESP: state_nx = req_valid ? ST_RESP : ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pa          <= '0;
            uncacheable <= 1'b0;
            fault       <= FLT_NONE;
            status      <= '0;
        end else if (req_valid) begin
            pa          <= nx_pa;
            uncacheable <= nx_unc;
            fault       <= nx_fault;
            status      <= nx_status;
        end
    end

    assign rsp_valid = (state == ST_RESP);
endmodule

// File: rtl/dxl_translate_chk.sv
module dxl_translate_chk
    import dxl_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            rsp_valid,
    input logic [PA_W-1:0] pa,
    input logic            uncacheable,
    input logic [2:0]      fault,
    input logic [ST_W-1:0] status
);
    // R1
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid));

    // R13
    fault_zero_pa_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && fault != 3'd0) |-> (pa == '0 && !uncacheable));

    // R12
    uc_field_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && uncacheable) |-> (pa[UC_CLR_HI:UC_CLR_LO] == '0));

    // R2
    align_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && fault == 3'd1) |-> (status[ST_W-1:1] == '0));

    // R7
    miss_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (fault == 3'd3 || fault == 3'd4)) |-> status[ST_MISS]);

    // R11
    mchk_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && fault == 3'd6) |-> (status == '0));

    // R12
    ok_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && fault == 3'd0) |-> (status == '0));

    // R2
    fault_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (fault <= 3'd6));
endmodule

bind dxl_translate dxl_translate_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .rsp_valid   (rsp_valid),
    .pa          (pa),
    .uncacheable (uncacheable),
    .fault       (fault),
    .status      (status)
);

// File: tb/dxl_translate_bench.sv
`timescale 1ns/1ps
module dxl_translate_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [63:0] va = '0;
    logic [1:0]  size_log2 = '0;
    logic        is_write = 1'b0, phys_req = 1'b0, alt_req = 1'b0, pal_mode = 1'b0;
    logic [1:0]  cur_mode = '0, alt_mode = '0;
    logic        sp_enable = 1'b0, pte_fetch = 1'b0, tlb_hit = 1'b0;
    logic [31:0] tlb_ppn = '0;
    logic [3:0]  tlb_rd_en = '0, tlb_wr_en = '0;
    logic        tlb_fonr = 1'b0, tlb_fonw = 1'b0;
    logic        rsp_valid, uncacheable;
    logic [43:0] pa;
    logic [2:0]  fault;
    logic [5:0]  status;

    int checks = 0;
    int errors = 0;
    logic [2:0]  e_fault;
    logic [5:0]  e_status;
    logic [43:0] e_pa;
    logic        e_unc;

    always #2 clk = ~clk;

    dxl_translate u_dxl_translate (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .va(va),
        .size_log2(size_log2), .is_write(is_write), .phys_req(phys_req),
        .alt_req(alt_req), .pal_mode(pal_mode), .cur_mode(cur_mode),
        .alt_mode(alt_mode), .sp_enable(sp_enable), .pte_fetch(pte_fetch),
        .tlb_hit(tlb_hit), .tlb_ppn(tlb_ppn), .tlb_rd_en(tlb_rd_en),
        .tlb_wr_en(tlb_wr_en), .tlb_fonr(tlb_fonr), .tlb_fonw(tlb_fonw),
        .rsp_valid(rsp_valid), .pa(pa), .uncacheable(uncacheable),
        .fault(fault), .status(status)
    );

    task automatic predict();
        logic [63:0] raw;
        logic [1:0]  em;
        logic [5:0]  w;
        logic [7:0]  m;
        e_fault = 3'd0; e_status = 6'd0; e_pa = '0; e_unc = 1'b0; raw = '0;
        w = {5'd0, is_write};
        m = (8'd1 << size_log2) - 8'd1;
        em = pal_mode ? (alt_req ? alt_mode : 2'd0) : cur_mode;
        if ((va[7:0] & m) != 0) begin
            e_fault = 3'd1; e_status = w;
        end else if (phys_req) begin
            raw = va;
        end else if (va[63:42] != '0 && va[63:42] != '1) begin
            e_fault = 3'd5; e_status = w | 6'd32 | 6'd2;
        end else if (sp_enable && va[47:41] == 7'h7E) begin
            if (cur_mode != 2'd0) begin
                e_fault = 3'd2; e_status = w | 6'd2;
            end else begin
                raw = va & 64'h0FFF_FFFF_FFFF;
                if (raw[40]) raw = raw | 64'hF00_0000_0000;
                else raw = raw & 64'hFF_FFFF_FFFF;
            end
        end else if (!tlb_hit) begin
            e_fault = pte_fetch ? 3'd4 : 3'd3; e_status = w | 6'd16;
        end else begin
            raw = ({32'd0, tlb_ppn} * 64'd8192) + {51'd0, va[12:0]};
            if (is_write) begin
                if (!tlb_wr_en[em]) begin
                    e_fault = 3'd5; e_status = 6'd3 | (tlb_fonw ? 6'd8 : 6'd0);
                end else if (tlb_fonw) begin
                    e_fault = 3'd5; e_status = 6'd9;
                end
            end else begin
                if (!tlb_rd_en[em]) begin
                    e_fault = 3'd2; e_status = 6'd2 | (tlb_fonr ? 6'd4 : 6'd0);
                end else if (tlb_fonr) begin
                    e_fault = 3'd5; e_status = 6'd4;
                end
            end
        end
        if (e_fault == 3'd0) begin
            if (raw[63:44] != 0) begin
                e_fault = 3'd6;
            end else begin
                e_pa = raw[43:0];
                if (e_pa[39]) begin
                    e_unc = 1'b1;
                    e_pa[42:35] = 8'd0;
                end
            end
        end
    endtask

    task automatic run_check(input string req);
        predict();
        req_valid = 1'b1;
        @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b1 || fault !== e_fault || status !== e_status ||
            pa !== e_pa || uncacheable !== e_unc) begin
            errors++;
            $display("FAIL %s va=%h got v=%b f=%0d s=%b pa=%h u=%b exp v=1 f=%0d s=%b pa=%h u=%b",
                     req, va, rsp_valid, fault, status, pa, uncacheable,
                     e_fault, e_status, e_pa, e_unc);
        end
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++; // R1 reset state
        if (rsp_valid !== 1'b0 || fault !== 3'd0) begin
            errors++;
            $display("FAIL R1 reset got v=%b f=%0d exp v=0 f=0", rsp_valid, fault);
        end

        // R2 alignment sweep, checked ahead of a bad address
        phys_req = 1'b1;
        for (int s = 0; s < 4; s++)
            for (int lo = 0; lo < 8; lo++)
                for (int w = 0; w < 2; w++) begin
                    size_log2 = 2'(s); is_write = w[0];
                    va = 64'h8000_0000_0000_1000 | 64'(lo);
                    run_check("R2");
                end
        size_log2 = 2'd0;

        // R4 physical access ignores TLB and sign check
        tlb_hit = 1'b0;
        va = 64'h0000_0800_0000_1234; run_check("R4");
        va = 64'h0000_0080_0001_2345; run_check("R4_R12");
        va = 64'h0000_1000_0000_0000; run_check("R4_R11");
        va = 64'h8000_0000_0000_0000; run_check("R4_R11");
        phys_req = 1'b0;

        // R5 bad virtual address patterns
        for (int w = 0; w < 2; w++) begin
            is_write = w[0];
            va = 64'h0000_0800_0000_0000; run_check("R5");
            va = 64'h8000_0000_0000_0000; run_check("R5");
            va = 64'hFFFF_F400_0000_0000; run_check("R5");
        end
        va = 64'hFFFF_FC00_0000_0040; run_check("R5_R7");

        // R6 direct-mapped window
        for (int c = 0; c < 4; c++)
            for (int b = 0; b < 4; b++)
                for (int e = 0; e < 2; e++)
                    for (int w = 0; w < 2; w++) begin
                        cur_mode = 2'(c); sp_enable = e[0]; is_write = w[0];
                        pal_mode = 1'b1; alt_req = 1'b0;
                        va = 64'hFFFF_FC00_0000_0000 | (64'(b) << 39) | 64'h00A8;
                        tlb_hit = 1'b0;
                        run_check("R6");
                    end
        sp_enable = 1'b0; pal_mode = 1'b0;

        // R7 miss variants
        va = 64'h0000_0000_0002_4AB8;
        for (int p = 0; p < 2; p++)
            for (int w = 0; w < 2; w++) begin
                pte_fetch = p[0]; is_write = w[0]; tlb_hit = 1'b0;
                run_check("R7");
            end
        pte_fetch = 1'b0;

        // R3 R8 R9 R10 full mode and enable sweep
        tlb_hit = 1'b1; tlb_ppn = 32'h0000_1234;
        for (int pm = 0; pm < 2; pm++)
            for (int ar = 0; ar < 2; ar++)
                for (int cm = 0; cm < 4; cm++)
                    for (int am = 0; am < 4; am++)
                        for (int en = 0; en < 16; en++)
                            for (int f = 0; f < 4; f++)
                                for (int w = 0; w < 2; w++) begin
                                    pal_mode = pm[0]; alt_req = ar[0];
                                    cur_mode = 2'(cm); alt_mode = 2'(am);
                                    tlb_rd_en = 4'(en); tlb_wr_en = 4'(en);
                                    tlb_fonr = f[0]; tlb_fonw = f[1];
                                    is_write = w[0];
                                    run_check(w[0] ? "R3_R9" : "R3_R10");
                                end
        pal_mode = 1'b0; alt_req = 1'b0; cur_mode = 2'd0;
        tlb_rd_en = 4'hF; tlb_wr_en = 4'hF; tlb_fonr = 1'b0; tlb_fonw = 1'b0;

        // R8 R11 R12 address composition on hits
        tlb_ppn = 32'h0400_1234; run_check("R8_R12");
        tlb_ppn = 32'h8000_0001; run_check("R11");
        tlb_ppn = 32'h07FF_FFFF; va = 64'h1FFF; run_check("R8_R12");
        tlb_ppn = 32'h0000_0001; va = 64'h0; run_check("R8");

        // R1 response drops when no request
        req_valid = 1'b0;
        @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1 idle got v=%b exp v=0", rsp_valid);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule